// File: doc/BRIEF.md
# Watchdog Timer with Guarded Switch-Off

The block counts ticks of a slow watchdog oscillator, which reaches it as a one-cycle tick-enable input in the system clock domain. Once the count reaches a timeout picked by a 3-bit select, it raises a one-cycle reset request. Software must keep pulsing a restart strobe to prevent this. A single write port loads a small control register. That register holds the run bit, an unlock bit and the timeout select, and it can be read back at all times.

A single write cannot switch off a running watchdog. Software first writes a word with both the unlock bit and the run bit set. This opens a short window. A write that clears the run bit inside that window stops the watchdog. Outside the window the same write leaves it running. When the window lapses, the hardware drops the unlock bit by itself.

The timeout is `2^(BASE_LOG2 + sel)` oscillator ticks. With the default `BASE_LOG2 = 14`, the select runs from 16K ticks to 2048K ticks.

Top module: `wdt_guard`

## Requirements
- R1: After reset the readback `ctrl_rd` is all zero: stopped, unlock clear, select 0. `wdt_rst` is low and the tick count is zero.
- R2: A write loads `wr_data`, and `ctrl_rd` shows it with the same layout: bits [2:0] are the timeout select, bit 3 is the run bit and bit 4 is the unlock bit. The select is always taken from the written word.
- R3: While running, the tick that brings the count to `2^(BASE_LOG2+sel)` ticks since the last clear makes `wdt_rst` high for exactly one clock cycle, in the cycle after that tick is sampled. The count goes back to zero, so the next request follows one full period later.
- R4: The count advances only on a clock edge where `tick` is high and the block is running. While stopped the count holds its value.
- R5: A high `kick` clears the count to zero and takes priority over a tick in the same cycle. The next request comes a full period after the kick.
- R6: Starting the block does not clear the count. Counting resumes from the value held while stopped.
- R7: A write with bits 4 and 3 both set opens a window of `WIN_CYC` (default 4) clock cycles. A write with bit 3 clear on any of those cycles stops the watchdog.
- R8: If no write consumes the window, the unlock bit clears on its own on the last window cycle. After that, a write with bit 3 clear leaves the watchdog running.
- R9: A change of select while running applies from the next tick. If the count has already passed the new limit, that next tick raises the request.
- R10: `wdt_rst` never rises while the watchdog is stopped, however many ticks arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 5 | Control word: [4] unlock, [3] run, [2:0] timeout select |
| kick | input | 1 | Restart strobe, clears the tick count |
| tick | input | 1 | Watchdog oscillator tick enable |
| wdt_rst | output | 1 | One-cycle reset request on timeout |
| ctrl_rd | output | 5 | Control register readback, same layout as `wr_data` |

## Verification
Every fault in the count shows up at the ports as a reset request that arrives on the wrong tick or does not arrive. The scoreboard therefore ties each request to the exact clock edge it should follow, and a held or lost count is exposed within one timeout period. A fault in the window logic shows in `ctrl_rd` one cycle after the write or lapse that causes it. The bench probes the last cycle inside the window and the first cycle outside it.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;
  localparam int SEL_W  = 3;
  localparam int N_SEL  = 1 << SEL_W;
  localparam int CTRL_W = SEL_W + 2;

  typedef struct packed {
    logic             arm;
    logic             en;
    logic [SEL_W-1:0] sel;
  } ctrl_t;
endpackage

// File: rtl/wdt_guard_rst_sync.sv
module wdt_guard_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/wdt_guard_ctrl.sv
module wdt_guard_ctrl
  import wdt_guard_pkg::*;
#(
  parameter int WIN_CYC = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  ctrl_t wr_word,
  output ctrl_t ctrl_q
);
  localparam int WIN_W = $clog2(WIN_CYC + 1);

  ctrl_t            ctrl_d;
  logic [WIN_W-1:0] win_q;
  logic [WIN_W-1:0] win_d;
  logic             unlock_req;

  assign unlock_req = wr_word.arm & wr_word.en;

  always_comb begin
    ctrl_d = ctrl_q;
    win_d  = win_q;
    if (wr_en) begin
      ctrl_d.sel = wr_word.sel;
      // a running watchdog only stops when the window is open
      if (!ctrl_q.en || ctrl_q.arm) ctrl_d.en = wr_word.en;
      else                          ctrl_d.en = 1'b1;
      if (unlock_req) begin
        ctrl_d.arm = 1'b1;
        win_d      = WIN_W'(WIN_CYC);
      end else begin
        ctrl_d.arm = 1'b0;
        win_d      = '0;
      end
    end else if (ctrl_q.arm) begin
      if (win_q <= WIN_W'(1)) begin
        ctrl_d.arm = 1'b0;
        win_d      = '0;
      end else begin
        win_d = win_q - WIN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      win_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      win_q  <= win_d;
    end
  end
endmodule

// File: rtl/wdt_guard_limit.sv
module wdt_guard_limit
  import wdt_guard_pkg::*;
#(
  parameter int BASE_LOG2 = 14,
  parameter int CNT_W     = BASE_LOG2 + N_SEL
) (
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] last_val
);
  logic [CNT_W-1:0] lim_tbl [N_SEL];

  for (genvar g = 0; g < N_SEL; g++) begin : g_lim
    assign lim_tbl[g] = (CNT_W'(1) << (BASE_LOG2 + g)) - CNT_W'(1);
  end

  assign last_val = lim_tbl[sel];
endmodule

// File: rtl/wdt_guard_count.sv
module wdt_guard_count #(
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             kick,
  input  logic [CNT_W-1:0] last_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             fire_q
);
  logic [CNT_W-1:0] cnt_d;
  logic             fire_d;
  logic             adv;

  assign adv = run & tick;

  always_comb begin
    cnt_d  = cnt_q;
    fire_d = 1'b0;
    if (kick) begin
      cnt_d = '0;
    end else if (adv) begin
      if (cnt_q >= last_val) begin
        cnt_d  = '0;
        fire_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      fire_q <= fire_d;
    end
  end
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_guard_pkg::*;
#(
  parameter int BASE_LOG2 = 14,
  parameter int WIN_CYC   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              kick,
  input  logic              tick,
  output logic              wdt_rst,
  output logic [CTRL_W-1:0] ctrl_rd
);
  localparam int CNT_W = BASE_LOG2 + N_SEL;

  logic             rst_sync_n;
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] last_val;
  logic [CNT_W-1:0] cnt_q;

  wdt_guard_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_sync_n)
  );

  wdt_guard_ctrl #(.WIN_CYC(WIN_CYC)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_word (ctrl_t'(wr_data)),
    .ctrl_q  (ctrl_q)
  );

  wdt_guard_limit #(.BASE_LOG2(BASE_LOG2), .CNT_W(CNT_W)) u_lim (
    .sel      (ctrl_q.sel),
    .last_val (last_val)
  );

  wdt_guard_count #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (ctrl_q.en),
    .tick     (tick),
    .kick     (kick),
    .last_val (last_val),
    .cnt_q    (cnt_q),
    .fire_q   (wdt_rst)
  );

  assign ctrl_rd = ctrl_q;
endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk #(
  parameter int CNT_W = 22
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             kick,
  input logic             tick,
  input logic             wdt_rst,
  input logic [4:0]       ctrl_rd,
  input logic [CNT_W-1:0] cnt_q
);
  p_pulse_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> !wdt_rst);

  p_pulse_count_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> (cnt_q == '0));

  p_pulse_after_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> $past(tick));

  p_hold_without_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !kick) |=> $stable(cnt_q));

  p_kick_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (cnt_q == '0));

  p_stop_needs_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_rd[3]) |-> ($past(ctrl_rd[4]) && $past(wr_en)));

  p_no_pulse_stopped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> $past(ctrl_rd[3]));
endmodule

bind wdt_guard wdt_guard_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .wr_en   (wr_en),
  .kick    (kick),
  .tick    (tick),
  .wdt_rst (wdt_rst),
  .ctrl_rd (ctrl_rd),
  .cnt_q   (cnt_q)
);

// File: tb/wdt_guard_test.sv
module wdt_guard_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [4:0] wr_data;
  logic       kick;
  logic       tick;
  logic       wdt_rst;
  logic [4:0] ctrl_rd;

  int compared   = 0;
  int mismatched = 0;
  int cyc        = 0;
  bit done       = 1'b0;
  int exp_q[$];
  int exp_cyc;

  always #5 clk = ~clk;

  wdt_guard #(.BASE_LOG2(2), .WIN_CYC(4)) uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .kick    (kick),
    .tick    (tick),
    .wdt_rst (wdt_rst),
    .ctrl_rd (ctrl_rd)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: every request must match the next expected edge
  always @(negedge clk) begin
    if (wdt_rst === 1'b1) begin
      compared++;
      if (exp_q.size() == 0) begin
        mismatched++;
        $display("FAIL R3/R10: unexpected wdt_rst at edge %0d, expected none", cyc);
      end else begin
        exp_cyc = exp_q.pop_front();
        if (exp_cyc != cyc) begin
          mismatched++;
          $display("FAIL R3: wdt_rst at edge %0d, expected %0d", cyc, exp_cyc);
        end
      end
    end
  end

  task automatic drive(input logic w, input logic [4:0] d, input logic t,
                       input logic k, input bit expect_fire);
    @(negedge clk);
    wr_en = w; wr_data = d; tick = t; kick = k;
    if (expect_fire) exp_q.push_back(cyc + 1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 5'd0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic ticks(input int n, input bit last_fires);
    for (int i = 0; i < n; i++)
      drive(1'b0, 5'd0, 1'b1, 1'b0, last_fires && (i == n - 1));
  endtask

  task automatic wr(input logic [4:0] d);
    drive(1'b1, d, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic check_ctrl(input logic [4:0] exp, input string req);
    compared++;
    if (ctrl_rd !== exp) begin
      mismatched++;
      $display("FAIL %s: ctrl_rd=%b expected %b", req, ctrl_rd, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; kick = 1'b0; tick = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    check_ctrl(5'b00000, "R1");
    compared++;
    if (wdt_rst !== 1'b0) begin
      mismatched++;
      $display("FAIL R1: wdt_rst=%b expected 0", wdt_rst);
    end

    // R2 load and readback, R3 timeout of 4 ticks at sel 0, repeated
    drive(1'b0, 5'd0, 1'b0, 1'b1, 1'b0);
    wr(5'b01000);
    idle(1);
    check_ctrl(5'b01000, "R2");
    ticks(4, 1'b1);
    ticks(4, 1'b1);

    // R4 count holds while no tick arrives
    ticks(2, 1'b0);
    idle(10);
    ticks(2, 1'b1);

    // R5 kick restarts a full period
    ticks(3, 1'b0);
    drive(1'b0, 5'd0, 1'b0, 1'b1, 1'b0);
    ticks(3, 1'b0);
    ticks(1, 1'b1);

    // R9 select lowered below the current count fires on the next tick
    wr(5'b01001);
    ticks(5, 1'b0);
    wr(5'b01000);
    ticks(1, 1'b1);
    check_ctrl(5'b01000, "R9");

    // R8 stop write without a window is ignored
    wr(5'b00000);
    idle(1);
    check_ctrl(5'b01000, "R8");
    ticks(4, 1'b1);

    // R8 window lapses: unlock still set on last cycle, then cleared
    wr(5'b11000);
    idle(1);
    check_ctrl(5'b11000, "R7");
    idle(2);
    idle(1);
    check_ctrl(5'b11000, "R8");
    wr(5'b00000);
    check_ctrl(5'b01000, "R8");
    idle(1);
    check_ctrl(5'b01000, "R8");

    // R7 stop on the last window cycle, count left at 2
    ticks(2, 1'b0);
    wr(5'b11000);
    idle(3);
    wr(5'b00000);
    idle(1);
    check_ctrl(5'b00000, "R7");

    // R10 no request while stopped
    ticks(10, 1'b0);
    check_ctrl(5'b00000, "R10");

    // R6 restart resumes from the held count of 2
    wr(5'b01000);
    ticks(2, 1'b1);

    // R7 stop on the first window cycle, R2 select taken from the word
    wr(5'b11000);
    wr(5'b00011);
    idle(1);
    check_ctrl(5'b00011, "R7");

    // R3 longest select: 512 ticks
    drive(1'b0, 5'd0, 1'b0, 1'b1, 1'b0);
    wr(5'b01111);
    ticks(511, 1'b0);
    ticks(1, 1'b1);

    idle(6);
    compared++;
    if (exp_q.size() != 0) begin
      mismatched++;
      $display("FAIL R3: %0d requests missing, expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule